// File: doc/BRIEF.md
# Serial Slow-Control Bus Master

This block drives a board-level slow-control link that works much like I2C. There is one serial clock and two one-way data lines: one carries data out from the master, and the other carries data back from the cards. A command gives a read/write flag, a 4-bit card number, a broadcast flag, a 5-bit register number and 16 bits of write data. The master turns the command into a fixed four-byte frame, checks for an acknowledge after each byte, and gathers read data from the return line. It then reports the result through a one-cycle write port into a result memory.

Every bus bit takes one bus-clock period of `2*HALF_CLKS` system clocks. The clock line is low for the first half of the period and high for the second half. The master changes the outgoing line only while the clock is low. It samples the return line in the last system cycle of the high half. Broadcast commands ignore acknowledges. Any other command that receives no acknowledge stops at that point and writes an error result.

Top module: `sc_bus_master`

## Requirements
- R1: After reset and whenever the master is idle, `scl` = 1, `sda_out` = 1, `busy` = 0 and `res_we` = 0.
- R2: A command is taken when `cmd_valid` is high and `busy` is low. While `busy` is high, `cmd_valid` is ignored. `busy` goes high in the cycle after acceptance and stays high up to and including the result-write cycle.
- R3: A frame opens with one start slot in which `scl` stays high and `sda_out` falls half-way through. It closes with one stop slot in which `sda_out` is low while `scl` goes low and then high. `sda_out` rises, with `scl` still high, in the cycle that follows. No other change of `sda_out` happens while `scl` is high.
- R4: Between start and stop come byte slots. Each byte slot is 8 data bits sent MSB first, followed by one acknowledge bit. In the acknowledge bit the master holds `sda_out` high.
- R5: Byte 1 (header): bit 0 is read (1) or write (0), bits 4:1 are the card number, bit 6 is the broadcast flag, and bits 5 and 7 are sent as 0. Byte 2 carries the register number in bits 4:0, with bits 7:5 sent as 0. Bytes 3 and 4 are the write data, high byte first.
- R6: An acknowledge is `sda_in` = 0, sampled at the end of the high half of the acknowledge bit.
- R7: On a non-broadcast command, a missing acknowledge after any byte sends the frame straight to the stop slot. The result then has `res_err` = 1 and `res_data` = 0.
- R8: A broadcast command always sends all four bytes, whatever appears on `sda_in`, and finishes with `res_err` = 0.
- R9: On a read, `sda_out` stays high during bytes 3 and 4. The 16 `sda_in` bits of those bytes, taken MSB first, become `res_data`.
- R10: Each command produces exactly one single-cycle `res_we` pulse. `res_addr` = {card, register}, with the card number in bits 8:5. `res_data` is 0 for writes and for errors.
- R11: Every slot lasts `2*HALF_CLKS` cycles. `busy` is high without `res_we` for `(2 + 9*n) * 2*HALF_CLKS` cycles, where n is the number of bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_rw | input | 1 | 1 = read, 0 = write |
| cmd_card | input | 4 | Card number |
| cmd_bcast | input | 1 | Broadcast flag |
| cmd_reg | input | 5 | Register number on the card |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| scl | output | 1 | Serial bus clock |
| sda_out | output | 1 | Serial data from master |
| sda_in | input | 1 | Serial data from cards |
| res_we | output | 1 | Result write strobe |
| res_addr | output | 9 | Result address {card, register} |
| res_data | output | 16 | Read data, else 0 |
| res_err | output | 1 | Missing acknowledge |

## Verification
The bench builds the master with `HALF_CLKS` = 2, so each bus bit is four system cycles. A whole frame then takes about 150 cycles, which lets every abort point and every frame length be run many times. With two cycles per half period, each clock edge, sampling point and data change sits next to the slot boundary. An off-by-one in the slot timer therefore shows up at once, both in the bit pattern the bench slave captures and in the counted `busy` length.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int CARD_W  = 4;
  localparam int REG_W   = 5;
  localparam int DATA_W  = 16;
  localparam int NBYTES  = 4;
  localparam int FRAME_W = 8 * NBYTES;
  localparam int ADDR_W  = CARD_W + REG_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BITS, ST_STOP, ST_DONE
  } sc_state_e;

  // header: [0]=rw, [4:1]=card, [6]=broadcast, [5],[7]=0
  function automatic logic [7:0] hdr_byte(input logic rw,
                                          input logic [CARD_W-1:0] card,
                                          input logic bcast);
    return {1'b0, bcast, 1'b0, card, rw};
  endfunction

  function automatic logic [FRAME_W-1:0] frame_word(
      input logic rw, input logic [CARD_W-1:0] card, input logic bcast,
      input logic [REG_W-1:0] rg, input logic [DATA_W-1:0] wd);
    return {hdr_byte(rw, card, bcast), 3'b000, rg, wd};
  endfunction

  function automatic logic [ADDR_W-1:0] result_addr(
      input logic [CARD_W-1:0] card, input logic [REG_W-1:0] rg);
    return {card, rg};
  endfunction
endpackage

// File: rtl/sc_bitclk.sv
module sc_bitclk #(
  parameter int HALF_CLKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_hi,
  output logic slot_last
);
  localparam int PERIOD = 2 * HALF_CLKS;
  localparam int CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt;

  assign phase_hi  = (cnt >= CW'(HALF_CLKS));
  assign slot_last = run && (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (slot_last) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  // R11: a slot never ends inside the low half
  slot_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_last |-> phase_hi);
endmodule

// File: rtl/sc_tx_shift.sv
module sc_tx_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sreg;

  assign msb = sreg[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)     sreg <= '0;
    else if (load)  sreg <= load_val;
    else if (shift) sreg <= {sreg[W-2:0], 1'b0};
  end
endmodule

// File: rtl/sc_rx_shift.sv
module sc_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n)     dout <= '0;
    else if (clr)   dout <= '0;
    else if (shift) dout <= {dout[W-2:0], din};
  end

  // R9: collection never clears and shifts at once
  rx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && shift));
endmodule

// File: rtl/sc_bus_master.sv
module sc_bus_master
  import sc_pkg::*;
#(
  parameter int HALF_CLKS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_rw,
  input  logic [CARD_W-1:0] cmd_card,
  input  logic              cmd_bcast,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              scl,
  output logic              sda_out,
  input  logic              sda_in,
  output logic              res_we,
  output logic [ADDR_W-1:0] res_addr,
  output logic [DATA_W-1:0] res_data,
  output logic              res_err
);
  localparam logic [3:0] ACK_BIT   = 4'd8;
  localparam logic [1:0] LAST_BYTE = 2'(NBYTES - 1);

  sc_state_e         fsm;
  logic [3:0]        bit_idx;
  logic [1:0]        byte_idx;
  logic              rw_q, bcast_q, err_q;
  logic [CARD_W-1:0] card_q;
  logic [REG_W-1:0]  reg_q;

  // named events
  logic accept, run, phase_hi, slot_last;
  logic ack_slot, data_phase, rx_slot, nack_abort, bit_end;
  logic tx_bit;
  logic [DATA_W-1:0] rx_data;

  assign accept     = (fsm == ST_IDLE) && cmd_valid;
  assign run        = (fsm == ST_START) || (fsm == ST_BITS) || (fsm == ST_STOP);
  assign ack_slot   = (bit_idx == ACK_BIT);
  assign data_phase = byte_idx[1];
  assign bit_end    = (fsm == ST_BITS) && slot_last;
  assign rx_slot    = rw_q && data_phase && !ack_slot;
  assign nack_abort = bit_end && ack_slot && sda_in && !bcast_q;

  sc_bitclk #(.HALF_CLKS(HALF_CLKS)) u_bitclk (
    .clk(clk), .rst_n(rst_n), .run(run),
    .phase_hi(phase_hi), .slot_last(slot_last));

  sc_tx_shift #(.W(FRAME_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .load_val(frame_word(cmd_rw, cmd_card, cmd_bcast, cmd_reg, cmd_wdata)),
    .shift(bit_end && !ack_slot), .msb(tx_bit));

  sc_rx_shift #(.W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(accept),
    .shift(bit_end && rx_slot), .din(sda_in), .dout(rx_data));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm      <= ST_IDLE;
      bit_idx  <= '0;
      byte_idx <= '0;
      rw_q     <= 1'b0;
      bcast_q  <= 1'b0;
      err_q    <= 1'b0;
      card_q   <= '0;
      reg_q    <= '0;
    end else begin
      unique case (fsm)
        ST_IDLE: if (accept) begin
          rw_q     <= cmd_rw;
          bcast_q  <= cmd_bcast;
          card_q   <= cmd_card;
          reg_q    <= cmd_reg;
          err_q    <= 1'b0;
          bit_idx  <= '0;
          byte_idx <= '0;
          fsm      <= ST_START;
        end
        ST_START: if (slot_last) fsm <= ST_BITS;
        ST_BITS: if (slot_last) begin
          if (!ack_slot) begin
            bit_idx <= bit_idx + 4'd1;
          end else if (nack_abort) begin
            err_q <= 1'b1;
            fsm   <= ST_STOP;
          end else if (byte_idx == LAST_BYTE) begin
            fsm <= ST_STOP;
          end else begin
            byte_idx <= byte_idx + 2'd1;
            bit_idx  <= '0;
          end
        end
        ST_STOP: if (slot_last) fsm <= ST_DONE;
        ST_DONE: fsm <= ST_IDLE;
        default: fsm <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    scl     = 1'b1;
    sda_out = 1'b1;
    unique case (fsm)
      ST_START: sda_out = !phase_hi;
      ST_BITS: begin
        scl     = phase_hi;
        sda_out = (ack_slot || (rw_q && data_phase)) ? 1'b1 : tx_bit;
      end
      ST_STOP: begin
        scl     = phase_hi;
        sda_out = 1'b0;
      end
      default: ;
    endcase
  end

  assign busy     = (fsm != ST_IDLE);
  assign res_we   = (fsm == ST_DONE);
  assign res_addr = result_addr(card_q, reg_q);
  assign res_data = (rw_q && !err_q) ? rx_data : '0;
  assign res_err  = err_q;

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl && sda_out && !res_we));
  // R2
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy && fsm != ST_START) |=> fsm != ST_START);
  // R3
  start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_out) && scl && $past(scl)) |-> fsm == ST_START);
  // R3
  stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_out) && scl && $past(scl)) |-> fsm == ST_DONE);
  // R8
  bcast_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && bcast_q) |-> !res_err);
  // R10
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> (!res_we && !busy));
  // R10
  write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && !rw_q) |-> res_data == '0);
endmodule

// File: tb/tb_sc_bus_master.sv
module tb_sc_bus_master;
  localparam int HALF = 2;
  localparam int SLOT = 2 * HALF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_rw = 1'b0, cmd_bcast = 1'b0;
  logic [3:0] cmd_card = '0;
  logic [4:0] cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic busy, scl, sda_out, res_we, res_err;
  logic sda_in = 1'b1;
  logic [8:0] res_addr;
  logic [15:0] res_data;

  always #5 clk = ~clk;

  sc_bus_master #(.HALF_CLKS(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rw(cmd_rw),
    .cmd_card(cmd_card), .cmd_bcast(cmd_bcast), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .busy(busy), .scl(scl), .sda_out(sda_out),
    .sda_in(sda_in), .res_we(res_we), .res_addr(res_addr),
    .res_data(res_data), .res_err(res_err));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench slave: watches the lines, answers on sda_in, captures bits
  logic prev_scl = 1'b1, prev_sda = 1'b1;
  bit   in_frame = 0;
  int   slot = -1, starts = 0, stops = 0;
  logic [31:0] cap = '0;
  bit   slv_rw = 0;
  int   slv_nack = 4;
  logic [15:0] slv_rdata = '0;

  always @(negedge clk) begin
    if (scl && prev_scl && prev_sda && !sda_out) begin
      in_frame = 1; slot = -1; starts++;
    end
    if (scl && prev_scl && !prev_sda && sda_out) begin
      in_frame = 0; stops++;
    end
    if (in_frame && prev_scl && !scl) begin
      slot++;
      if (slot >= 36) sda_in <= 1'b1;
      else if (slot % 9 == 8) sda_in <= (slot / 9 >= slv_nack);
      else if (slv_rw && slot / 9 >= 2)
        sda_in <= slv_rdata[15 - ((slot / 9 - 2) * 8 + slot % 9)];
      else sda_in <= 1'b1;
    end
    if (in_frame && !prev_scl && scl && slot >= 0 && slot < 36 && slot % 9 != 8)
      cap[31 - ((slot / 9) * 8 + slot % 9)] = sda_out;
    prev_scl = scl;
    prev_sda = sda_out;
  end

  // one command with full checking; poke drives a stray command while busy
  task automatic do_cmd(input bit rw, input logic [3:0] card, input bit bc,
                        input logic [4:0] rg, input logic [15:0] wd,
                        input logic [15:0] rd, input int nack, input bit poke);
    int cyc = 0, guard = 0, nb;
    bit err;
    logic [7:0] hdr;
    logic [31:0] full;
    err  = (nack < 4) && !bc;
    nb   = err ? nack + 1 : 4;
    hdr  = {1'b0, bc, 1'b0, card, rw};
    full = {hdr, 3'b000, rg, rw ? 16'hFFFF : wd};
    @(negedge clk);
    slv_rw = rw; slv_nack = nack; slv_rdata = rd;
    starts = 0; stops = 0; cap = '0;
    cmd_valid = 1; cmd_rw = rw; cmd_card = card; cmd_bcast = bc;
    cmd_reg = rg; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 0;
    chk(busy === 1'b1, "R2 busy after accept", busy, 1);
    while (!res_we && guard < 3000) begin
      if (busy) cyc++;
      if (poke && cyc == 10) begin
        cmd_valid = 1; cmd_card = ~card; cmd_reg = ~rg;
      end else cmd_valid = 0;
      guard++;
      @(negedge clk);
    end
    cmd_valid = 0;
    chk(res_we === 1'b1, "R10 result strobe", res_we, 1);
    chk(cyc == (2 + 9 * nb) * SLOT, "R11 busy length", cyc, (2 + 9 * nb) * SLOT);
    chk(res_err === err, "R7/R8 error flag", res_err, err);
    chk(res_addr === {card, rg}, "R10 result address", res_addr, {card, rg});
    chk(res_data === ((rw && !err) ? rd : 16'h0), "R9/R10 result data",
        res_data, (rw && !err) ? rd : 16'h0);
    chk(cap[31:24] === hdr, "R5 header byte", cap[31:24], hdr);
    if (nb == 4) chk(cap === full, "R4/R5 frame bits", cap, full);
    @(negedge clk);
    chk(busy === 1'b0 && res_we === 1'b0, "R10 single pulse", {busy, res_we}, 0);
    chk(starts == 1 && stops == 1, "R3 start/stop count", {starts[15:0], stops[15:0]},
        32'h0001_0001);
  endtask

  // [45] rw [44:41] card [40] bcast [39:35] reg [34:19] wdata [18:3] rdata [2:0] nack
  localparam logic [45:0] VEC [0:6] = '{
    {1'b0, 4'd5,  1'b0, 5'h13, 16'hA5C3, 16'h0000, 3'd4},
    {1'b1, 4'd9,  1'b0, 5'h07, 16'h0000, 16'h3C96, 3'd4},
    {1'b0, 4'd2,  1'b0, 5'h01, 16'hFFFF, 16'h0000, 3'd0},
    {1'b1, 4'd15, 1'b0, 5'h1F, 16'h0000, 16'hBEEF, 3'd2},
    {1'b0, 4'd0,  1'b1, 5'h04, 16'h1234, 16'h0000, 3'd0},
    {1'b0, 4'd6,  1'b0, 5'h0A, 16'h8001, 16'h0000, 3'd3},
    {1'b1, 4'd3,  1'b0, 5'h10, 16'h0000, 16'h5A5A, 3'd1}
  };

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R11 actual=%0d expected<150000", wd_cnt);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(scl === 1 && sda_out === 1, "R1 idle lines", {scl, sda_out}, 2'b11);
    chk(busy === 0 && res_we === 0, "R1 idle status", {busy, res_we}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(scl === 1 && sda_out === 1 && busy === 0, "R1 after reset",
        {scl, sda_out, busy}, 3'b110);
    for (int i = 0; i < 7; i++) begin
      logic [45:0] v;
      v = VEC[i];
      do_cmd(v[45], v[44:41], v[40], v[39:35], v[34:19], v[18:3], int'(v[2:0]), 0);
    end
    // R2: stray command during busy is ignored
    do_cmd(1'b0, 4'd12, 1'b0, 5'h05, 16'h0F0F, 16'h0, 4, 1);
    begin
      int extra = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (busy || res_we) extra++;
      end
      chk(extra == 0, "R2 busy command ignored", extra, 0);
    end
    // R8 broadcast read with every acknowledge missing
    do_cmd(1'b1, 4'd7, 1'b1, 5'h02, 16'h0, 16'hC001, 0, 0);
    // R6/R7 read with acknowledge missing on last byte
    do_cmd(1'b1, 4'd8, 1'b0, 5'h0C, 16'h0, 16'h1357, 3, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule